// File: doc/BRIEF.md
# Pipeline Hazard Resolution and Operand Forwarding Unit

This block resolves data and control hazards for a five-stage integer pipeline: fetch, decode, execute, memory and write-back. It watches the source and destination register numbers and the write-enable and load bits that travel with each instruction. From these it drives three things: the operand-bypass selects for both ALU inputs, a one-cycle load-use stall, and a flush of the decode stage when a branch resolved in decode is taken.

A small pipeline-register harness is part of the block. Instruction fields enter at the fetch side and move through the fetch/decode, decode/execute, execute/memory and memory/write-back registers. The stall and flush act on these registers, so their effect can be seen at the ports. Bypassing can take a result from the execute/memory register or the memory/write-back register. The nearer one wins. The register file writes before it reads within a cycle, so a producer in write-back needs no bypass for a consumer in decode. Branches are predicted not taken. Only a taken branch costs a cycle.

Top module: `hzd_fwd_unit`

## Requirements
- R1: After reset, every pipeline register is cleared: the decode and execute field outputs are zero, `fwd_a`/`fwd_b` are 2'b00, and `stall` and `flush` are 0.
- R2: When the execute stage's source register (rs for `fwd_a`, rt for `fwd_b`) equals the nonzero destination of the instruction in the execute/memory register, and that instruction has its write bit set, the select is 2'b10.
- R3: When the source register matches instead the nonzero, write-enabled destination in the memory/write-back register, the select is 2'b01. With no match the select is 2'b00, which means the register file.
- R4: When both later registers match the same source, the execute/memory register wins and the select is 2'b10.
- R5: A producer with destination register 0, or with its write bit low, causes no bypass (select 2'b00) and no stall.
- R6: `stall` is 1 while the decode/execute register holds a write-enabled load with a nonzero destination that equals the decode-stage rs or rt. It lasts exactly one cycle. A load whose destination matches neither source causes no stall.
- R7: On the clock edge that ends a stall cycle, the fetch/decode register keeps its contents and ignores the fetch inputs. The decode/execute register takes a bubble: write bit 0, load bit 0, destination 0.
- R8: After the stall, the dependent instruction reaches execute with the load in write-back, and its select is 2'b01.
- R9: A taken branch in decode with no stall pending raises `flush` in the same cycle. On the next edge the fetch/decode register is cleared, and the cleared slot enters execute as a no-op.
- R10: When `id_br_taken` is 0, the fetched instruction enters decode unchanged and `flush` stays 0.
- R11: A taken branch indication during a load-use stall gives `flush` = 0. The branch is held in decode with the stall.
- R12: A consumer that is three instructions behind its producer causes no stall. It reaches execute with a select of 2'b00, because the write-first register file supplies the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_rs | input | REG_AW | First source register of the fetched instruction |
| if_rt | input | REG_AW | Second source register of the fetched instruction |
| if_rd | input | REG_AW | Destination register of the fetched instruction |
| if_wr | input | 1 | Fetched instruction writes a register |
| if_mrd | input | 1 | Fetched instruction is a load |
| id_br_taken | input | 1 | Branch in decode resolved as taken |
| fwd_a | output | 2 | Bypass select for ALU operand A (rs) |
| fwd_b | output | 2 | Bypass select for ALU operand B (rt) |
| stall | output | 1 | Hold PC and fetch/decode, bubble into execute |
| flush | output | 1 | Clear fetch/decode on the next edge |
| id_rd_q | output | REG_AW | Destination field held in fetch/decode |
| id_wr_q | output | 1 | Write bit held in fetch/decode |
| id_mrd_q | output | 1 | Load bit held in fetch/decode |
| ex_rd_q | output | REG_AW | Destination field held in decode/execute |
| ex_wr_q | output | 1 | Write bit held in decode/execute |
| ex_mrd_q | output | 1 | Load bit held in decode/execute |

## Verification
The hardest case to reach is a taken branch that coincides with a load-use stall. It needs a load already in execute, a dependent instruction sitting in decode, and the branch indication raised in that same cycle. The bench builds it by pushing the load and then the consumer, and only then raising the branch input before the edge. It then checks that no flush occurs and that the decode contents survive. The bypass priority case is set up the same way. Two back-to-back writers of one register sit ahead of a reader, so the reader finds both later pipeline registers matching at the moment it is in execute.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   // Operand source chosen for an ALU input in execute
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,   // value read from the register file in decode
      FWD_WB  = 2'b01,   // bypass from memory/write-back register
      FWD_MEM = 2'b10    // bypass from execute/memory register
   } fwd_sel_e;
endpackage

// File: rtl/hzd_pipe_regs.sv
module hzd_pipe_regs #(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              flush,
   input  logic [REG_AW-1:0] if_rs,
   input  logic [REG_AW-1:0] if_rt,
   input  logic [REG_AW-1:0] if_rd,
   input  logic              if_wr,
   input  logic              if_mrd,
   output logic [REG_AW-1:0] id_rs,
   output logic [REG_AW-1:0] id_rt,
   output logic [REG_AW-1:0] id_rd,
   output logic              id_wr,
   output logic              id_mrd,
   output logic [REG_AW-1:0] ex_rs,
   output logic [REG_AW-1:0] ex_rt,
   output logic [REG_AW-1:0] ex_rd,
   output logic              ex_wr,
   output logic              ex_mrd,
   output logic [REG_AW-1:0] mem_rd,
   output logic              mem_wr,
   output logic [REG_AW-1:0] wb_rd,
   output logic              wb_wr
);
   localparam logic [REG_AW-1:0] NO_REG = '0;

   // fetch/decode: cleared by flush, frozen by stall
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_rs <= NO_REG; id_rt <= NO_REG; id_rd <= NO_REG;
         id_wr <= 1'b0;   id_mrd <= 1'b0;
      end else if (flush) begin
         id_rs <= NO_REG; id_rt <= NO_REG; id_rd <= NO_REG;
         id_wr <= 1'b0;   id_mrd <= 1'b0;
      end else if (!stall) begin
         id_rs <= if_rs;  id_rt <= if_rt;  id_rd <= if_rd;
         id_wr <= if_wr;  id_mrd <= if_mrd;
      end
   end

   // decode/execute: takes a bubble while stalled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_rs <= NO_REG; ex_rt <= NO_REG; ex_rd <= NO_REG;
         ex_wr <= 1'b0;   ex_mrd <= 1'b0;
      end else if (stall) begin
         ex_rs <= NO_REG; ex_rt <= NO_REG; ex_rd <= NO_REG;
         ex_wr <= 1'b0;   ex_mrd <= 1'b0;
      end else begin
         ex_rs <= id_rs;  ex_rt <= id_rt;  ex_rd <= id_rd;
         ex_wr <= id_wr;  ex_mrd <= id_mrd;
      end
   end

   // execute/memory and memory/write-back: destination and write bit travel on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rd <= NO_REG; mem_wr <= 1'b0;
         wb_rd  <= NO_REG; wb_wr  <= 1'b0;
      end else begin
         mem_rd <= ex_rd;  mem_wr <= ex_wr;
         wb_rd  <= mem_rd; wb_wr  <= mem_wr;
      end
   end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wr,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_wr,
   output hzd_pkg::fwd_sel_e sel
);
   import hzd_pkg::*;
   localparam logic [REG_AW-1:0] NO_REG = '0;

   logic mem_hit;
   logic wb_hit;

   always_comb begin
      mem_hit = mem_wr && (mem_rd != NO_REG) && (mem_rd == src);
      wb_hit  = wb_wr  && (wb_rd  != NO_REG) && (wb_rd  == src);
      if (mem_hit)     sel = FWD_MEM;   // nearest producer wins
      else if (wb_hit) sel = FWD_WB;
      else             sel = FWD_RF;
   end
endmodule

// File: rtl/hzd_stall_det.sv
module hzd_stall_det #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wr,
   input  logic              ex_mrd,
   input  logic              br_taken,
   output logic              stall,
   output logic              flush
);
   localparam logic [REG_AW-1:0] NO_REG = '0;

   logic load_live;

   always_comb begin
      load_live = ex_mrd && ex_wr && (ex_rd != NO_REG);
      stall     = load_live && ((ex_rd == id_rs) || (ex_rd == id_rt));
      // a stalled branch waits for its operands before resolving
      flush     = br_taken && !stall;
   end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit #(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] if_rs,
   input  logic [REG_AW-1:0] if_rt,
   input  logic [REG_AW-1:0] if_rd,
   input  logic              if_wr,
   input  logic              if_mrd,
   input  logic              id_br_taken,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic              stall,
   output logic              flush,
   output logic [REG_AW-1:0] id_rd_q,
   output logic              id_wr_q,
   output logic              id_mrd_q,
   output logic [REG_AW-1:0] ex_rd_q,
   output logic              ex_wr_q,
   output logic              ex_mrd_q
);
   import hzd_pkg::*;
   localparam int NUM_SRC = 2;

   if (REG_AW < 2 || REG_AW > 8) begin : g_bad_aw
      $error("hzd_fwd_unit: REG_AW must lie in 2..8");
   end

   logic [REG_AW-1:0] id_rs, id_rt, id_rd, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
   logic              id_wr, id_mrd, ex_wr, ex_mrd, mem_wr, wb_wr;
   logic [REG_AW-1:0] ex_src [NUM_SRC];
   fwd_sel_e          sel    [NUM_SRC];

   hzd_stall_det #(.REG_AW(REG_AW)) u_det (
      .id_rs(id_rs), .id_rt(id_rt), .ex_rd(ex_rd), .ex_wr(ex_wr),
      .ex_mrd(ex_mrd), .br_taken(id_br_taken), .stall(stall), .flush(flush)
   );

   hzd_pipe_regs #(.REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
      .if_rs(if_rs), .if_rt(if_rt), .if_rd(if_rd), .if_wr(if_wr), .if_mrd(if_mrd),
      .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd), .id_wr(id_wr), .id_mrd(id_mrd),
      .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_mrd(ex_mrd),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_rd(wb_rd), .wb_wr(wb_wr)
   );

   assign ex_src[0] = ex_rs;
   assign ex_src[1] = ex_rt;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
      hzd_fwd_sel #(.REG_AW(REG_AW)) u_sel (
         .src(ex_src[g]), .mem_rd(mem_rd), .mem_wr(mem_wr),
         .wb_rd(wb_rd), .wb_wr(wb_wr), .sel(sel[g])
      );
   end

   assign fwd_a    = sel[0];
   assign fwd_b    = sel[1];
   assign id_rd_q  = id_rd;
   assign id_wr_q  = id_wr;
   assign id_mrd_q = id_mrd;
   assign ex_rd_q  = ex_rd;
   assign ex_wr_q  = ex_wr;
   assign ex_mrd_q = ex_mrd;
endmodule

// File: rtl/hzd_fwd_unit_chk.sv
module hzd_fwd_unit_chk #(
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b,
   input logic              stall,
   input logic              flush,
   input logic              id_br_taken,
   input logic [REG_AW-1:0] id_rd_q,
   input logic              id_wr_q,
   input logic              id_mrd_q,
   input logic              ex_wr_q,
   input logic              ex_mrd_q
);
   // R2
   sel_code_a_chk: assert property (@(posedge clk) disable iff (!rst_n) fwd_a != 2'b11);
   // R2
   sel_code_b_chk: assert property (@(posedge clk) disable iff (!rst_n) fwd_b != 2'b11);
   // R6
   one_cycle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall);
   // R7
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (!ex_wr_q && !ex_mrd_q));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(id_rd_q) && $stable(id_wr_q) && $stable(id_mrd_q)));
   // R9
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (id_rd_q == '0 && !id_wr_q && !id_mrd_q));
   // R11
   branch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && id_br_taken) |-> !flush);
endmodule

bind hzd_fwd_unit hzd_fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall),
   .flush(flush), .id_br_taken(id_br_taken), .id_rd_q(id_rd_q), .id_wr_q(id_wr_q),
   .id_mrd_q(id_mrd_q), .ex_wr_q(ex_wr_q), .ex_mrd_q(ex_mrd_q)
);

// File: tb/hzd_fwd_unit_tb.sv
`timescale 1ns/1ps
module hzd_fwd_unit_tb;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] if_rs = '0, if_rt = '0, if_rd = '0;
   logic          if_wr = 1'b0, if_mrd = 1'b0, id_br_taken = 1'b0;
   logic [1:0]    fwd_a, fwd_b;
   logic          stall, flush;
   logic [AW-1:0] id_rd_q, ex_rd_q;
   logic          id_wr_q, id_mrd_q, ex_wr_q, ex_mrd_q;
   int            total = 0;
   int            bad = 0;
   bit            finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   hzd_fwd_unit #(.REG_AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .if_rs(if_rs), .if_rt(if_rt), .if_rd(if_rd),
      .if_wr(if_wr), .if_mrd(if_mrd), .id_br_taken(id_br_taken),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .flush(flush),
      .id_rd_q(id_rd_q), .id_wr_q(id_wr_q), .id_mrd_q(id_mrd_q),
      .ex_rd_q(ex_rd_q), .ex_wr_q(ex_wr_q), .ex_mrd_q(ex_mrd_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // place an instruction on the fetch inputs just after a falling edge
   task automatic drive(input int rs, input int rt, input int rd,
                        input bit wr, input bit mrd, input bit br);
      @(negedge clk);
      if_rs = AW'(rs); if_rt = AW'(rt); if_rd = AW'(rd);
      if_wr = wr; if_mrd = mrd; id_br_taken = br;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic push(input int rs, input int rt, input int rd, input bit wr, input bit mrd);
      drive(rs, rt, rd, wr, mrd, 1'b0);
      tick();
   endtask

   task automatic drain();
      for (int i = 0; i < 5; i++) push(0, 0, 0, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 fwd_a", fwd_a, 0);
      chk("R1 fwd_b", fwd_b, 0);
      chk("R1 stall", stall, 0);
      chk("R1 flush", flush, 0);
      chk("R1 id_wr", id_wr_q, 0);
      chk("R1 ex_wr", ex_wr_q, 0);
      chk("R1 ex_rd", ex_rd_q, 0);
   endtask

   task automatic t_mem_fwd();
      push(1, 2, 3, 1'b1, 1'b0);
      push(3, 8, 9, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R2 fwd_a from exe/mem", fwd_a, 2);
      chk("R2 fwd_b none", fwd_b, 0);
      drain();
      push(1, 2, 4, 1'b1, 1'b0);
      push(7, 4, 9, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R2 fwd_b from exe/mem", fwd_b, 2);
      chk("R2 fwd_a none", fwd_a, 0);
      drain();
   endtask

   task automatic t_wb_fwd();
      push(1, 2, 5, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      push(5, 5, 9, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R3 fwd_a from mem/wb", fwd_a, 1);
      chk("R3 fwd_b from mem/wb", fwd_b, 1);
      drain();
   endtask

   task automatic t_priority();
      push(1, 2, 6, 1'b1, 1'b0);
      push(1, 2, 6, 1'b1, 1'b0);
      push(6, 6, 9, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R4 fwd_a nearer wins", fwd_a, 2);
      chk("R4 fwd_b nearer wins", fwd_b, 2);
      drain();
   endtask

   task automatic t_zero_and_nowrite();
      push(1, 2, 0, 1'b1, 1'b0);
      push(0, 0, 9, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R5 reg0 fwd_a", fwd_a, 0);
      chk("R5 reg0 fwd_b", fwd_b, 0);
      drain();
      push(1, 2, 7, 1'b0, 1'b0);
      push(7, 7, 9, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R5 no-write fwd_a", fwd_a, 0);
      drain();
      push(1, 2, 0, 1'b1, 1'b1);
      drive(0, 0, 9, 1'b1, 1'b0, 1'b0);
      tick();
      chk("R5 load to reg0 no stall", stall, 0);
      drain();
   endtask

   task automatic t_load_use();
      push(1, 2, 4, 1'b1, 1'b1);
      push(4, 9, 6, 1'b1, 1'b0);
      drive(11, 12, 13, 1'b1, 1'b0, 1'b0);
      chk("R6 stall raised", stall, 1);
      tick();
      chk("R6 stall one cycle", stall, 0);
      chk("R7 decode held rd", id_rd_q, 6);
      chk("R7 bubble write bit", ex_wr_q, 0);
      chk("R7 bubble load bit", ex_mrd_q, 0);
      chk("R7 bubble rd", ex_rd_q, 0);
      drive(11, 12, 13, 1'b1, 1'b0, 1'b0);
      tick();
      chk("R8 fwd_a after stall", fwd_a, 1);
      chk("R8 consumer in execute", ex_rd_q, 6);
      drain();
      push(1, 2, 4, 1'b1, 1'b1);
      push(5, 9, 6, 1'b1, 1'b0);
      chk("R6 unrelated load no stall", stall, 0);
      drain();
   endtask

   task automatic t_branch();
      push(1, 2, 0, 1'b0, 1'b0);
      drive(3, 3, 7, 1'b1, 1'b1, 1'b1);
      chk("R9 flush raised", flush, 1);
      tick();
      chk("R9 decode cleared rd", id_rd_q, 0);
      chk("R9 decode cleared wr", id_wr_q, 0);
      chk("R9 decode cleared mrd", id_mrd_q, 0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R9 no-op in execute", ex_wr_q, 0);
      drain();
      push(1, 2, 0, 1'b0, 1'b0);
      drive(3, 3, 7, 1'b1, 1'b0, 1'b0);
      chk("R10 no flush", flush, 0);
      tick();
      chk("R10 fetched rd in decode", id_rd_q, 7);
      chk("R10 fetched wr in decode", id_wr_q, 1);
      drain();
   endtask

   task automatic t_branch_in_stall();
      push(1, 2, 4, 1'b1, 1'b1);
      push(4, 4, 0, 1'b0, 1'b0);
      drive(3, 3, 8, 1'b1, 1'b0, 1'b1);
      chk("R11 stall present", stall, 1);
      chk("R11 flush held off", flush, 0);
      tick();
      chk("R11 branch kept in decode", id_rd_q, 0);
      chk("R11 stall released", stall, 0);
      chk("R11 flush after stall", flush, 1);
      drive(3, 3, 8, 1'b1, 1'b0, 1'b0);
      tick();
      drain();
   endtask

   task automatic t_three_apart();
      push(1, 2, 5, 1'b1, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      push(0, 0, 0, 1'b0, 1'b0);
      push(5, 5, 9, 1'b1, 1'b0);
      chk("R12 no stall", stall, 0);
      push(0, 0, 0, 1'b0, 1'b0);
      chk("R12 fwd_a register file", fwd_a, 0);
      chk("R12 fwd_b register file", fwd_b, 0);
      drain();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_mem_fwd();
      t_wb_fwd();
      t_priority();
      t_zero_and_nowrite();
      t_load_use();
      t_branch();
      t_branch_in_stall();
      t_three_apart();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule